// File: doc/BRIEF.md
# External Event Line Controller

This block watches a bank of asynchronous input pins and turns pin activity into interrupt and wakeup requests for a processor. Each line runs through a two-stage synchroniser and an optional pulse-blocking deglitch filter. It then reaches a trigger detector that matches one of five trigger types. A match sets a sticky per-line pending bit. Software clears the bit by writing a one to it. Any line can also be triggered from software without pin activity. Two separate enable masks decide which pending bits reach the combined interrupt output and which reach the combined wakeup output.

Configuration uses a plain synchronous write port with an address, a data word and a write strobe. The pending vector is brought out directly so that the consumer can see which line fired. The bench relies on the same vector. Write-port register addresses are: 0 interrupt enable mask, 1 wakeup enable mask, 2 pending clear (write one to clear), 3 software trigger, 4 filter enable mask, 5 filter length (low 4 bits), and 16+n trigger type of line n.

Each line's deglitch filter is a four-state machine. The states are FL_LOW (accepted level low), FL_RISE (a high level is being qualified), FL_HIGH (accepted level high) and FL_FALL (a low level is being qualified). Its transitions are:
- FL_LOW to FL_RISE when the input is high.
- FL_RISE back to FL_LOW when the input drops before qualification.
- FL_RISE to FL_HIGH when the qualify counter reaches the filter length.
- FL_HIGH to FL_FALL when the input is low.
- FL_FALL back to FL_HIGH when the input returns high.
- FL_FALL to FL_LOW when the counter reaches the filter length.

Top module: `evl_ctrl`

## Requirements
- R1: There are 16 independent lines. After reset the pending vector is all zero, the interrupt output is 0 and the wakeup output is 0. A trigger on one line sets only that line's pending bit.
- R2: Trigger type codes are 0 rising edge, 1 falling edge, 2 both edges, 3 high level and 4 low level. The reset code is 0. With the filter off, a pin change made before clock edge 1 shows on the pending output after edge 3 and not before.
- R3: A falling-edge line (code 1) sets its bit only on a high-to-low change. A both-edge line (code 2) sets on either change.
- R4: A level line (code 3 high, code 4 low) sets its pending bit on every cycle the level holds. A clear write has no effect while the level is active. After the level goes away the bit stays set until it is cleared.
- R5: Trigger type codes 5, 6 and 7 disable pin triggering for that line.
- R6: A pending bit stays set until a one is written to its position at address 2. Writing zero bits to address 2 leaves pending bits unchanged.
- R7: When a trigger and a clear hit the same line on the same clock edge, the pending bit stays set.
- R8: Writing a one to bit n at address 3 sets pending bit n on that write's clock edge, whatever the line's trigger type.
- R9: With the filter enabled for a line (address 4) and filter length L (address 5), a new synchronised level is accepted only after it has been seen on L+2 consecutive clock edges. Shorter pulses never trigger the line. A line with its filter disabled triggers on a single-cycle pulse.
- R10: The interrupt output is 1 exactly when some pending bit has its interrupt enable set (address 0). The wakeup output is 1 exactly when some pending bit has its wakeup enable set (address 1). The two masks are independent.
- R11: A pending bit sets on a trigger whether or not its interrupt or wakeup enable is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 16 | Asynchronous event input pins, one per line |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 5 | Register write address |
| wr_data_i | input | 16 | Register write data |
| pending_o | output | 16 | Sticky per-line pending bits |
| irq_o | output | 1 | Combined interrupt request |
| wake_o | output | 1 | Combined wakeup request |

## Verification
A wrong bit in a pending register shows on `pending_o` at the next sample after the edge that stored it. If that line's enables are set, it also shows on `irq_o` or `wake_o` in the same sample. A filter state machine stuck in a qualifying state, or a miscounted qualify counter, shows as a missing or early pending bit. Since the filter length is known, the bench can place pulses one cycle either side of the acceptance threshold and see the error within a few cycles. A lost previous-level register in the edge detector shows as a spurious or missing pending bit on the third edge after a pin change.

// File: rtl/evl_pkg.sv
package evl_pkg;

    // trigger type codes held per line
    localparam logic [2:0] TRG_RISE = 3'd0;
    localparam logic [2:0] TRG_FALL = 3'd1;
    localparam logic [2:0] TRG_BOTH = 3'd2;
    localparam logic [2:0] TRG_HIGH = 3'd3;
    localparam logic [2:0] TRG_LOW  = 3'd4;

    // write port register map
    localparam int REG_IE   = 0;
    localparam int REG_WE   = 1;
    localparam int REG_CLR  = 2;
    localparam int REG_SWT  = 3;
    localparam int REG_FEN  = 4;
    localparam int REG_FLEN = 5;

    typedef enum logic [1:0] {
        FL_LOW  = 2'd0,
        FL_RISE = 2'd1,
        FL_HIGH = 2'd2,
        FL_FALL = 2'd3
    } flt_state_t;

endpackage

// File: rtl/evl_sync.sv
module evl_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q_o    <= '0;
        end else begin
            meta_q <= d_i;
            q_o    <= meta_q;
        end
    end

endmodule

// File: rtl/evl_filter.sv
module evl_filter
    import evl_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             raw_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             level_o
);

    flt_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FL_LOW;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            FL_LOW: begin
                if (raw_i) begin
                    state_d = FL_RISE;
                    cnt_d   = '0;
                end
            end
            FL_RISE: begin
                if (!raw_i) begin
                    state_d = FL_LOW;
                end else if (cnt_q == limit_i) begin
                    state_d = FL_HIGH;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            FL_HIGH: begin
                if (!raw_i) begin
                    state_d = FL_FALL;
                    cnt_d   = '0;
                end
            end
            FL_FALL: begin
                if (raw_i) begin
                    state_d = FL_HIGH;
                end else if (cnt_q == limit_i) begin
                    state_d = FL_LOW;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            default: state_d = FL_LOW;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            FL_HIGH, FL_FALL: level_o = 1'b1;
            default:          level_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/evl_detect.sv
module evl_detect
    import evl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       level_i,
    input  logic [2:0] mode_i,
    output logic       hit_o
);

    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level_i;
    end

    always_comb begin
        case (mode_i)
            TRG_RISE: hit_o = level_i & ~prev_q;
            TRG_FALL: hit_o = ~level_i & prev_q;
            TRG_BOTH: hit_o = level_i ^ prev_q;
            TRG_HIGH: hit_o = level_i;
            TRG_LOW:  hit_o = ~level_i;
            default:  hit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/evl_ctrl.sv
module evl_ctrl
    import evl_pkg::*;
#(
    parameter  int NUM_LINES = 16,
    parameter  int FLT_W     = 4,
    localparam int IDX_W     = $clog2(NUM_LINES),
    localparam int ADDR_W    = IDX_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] pin_i,
    input  logic                 wr_en_i,
    input  logic [ADDR_W-1:0]    wr_addr_i,
    input  logic [NUM_LINES-1:0] wr_data_i,
    output logic [NUM_LINES-1:0] pending_o,
    output logic                 irq_o,
    output logic                 wake_o
);

    logic [NUM_LINES-1:0] sync_q;
    logic [NUM_LINES-1:0] flt_lvl;
    logic [NUM_LINES-1:0] line_lvl;
    logic [NUM_LINES-1:0] hit;
    logic [NUM_LINES-1:0] ie_q, we_q, fen_q, pend_q;
    logic [NUM_LINES-1:0] clr_m, swt_m;
    logic [FLT_W-1:0]     flen_q;

    logic sel_ie, sel_we, sel_clr, sel_swt, sel_fen, sel_flen;

    assign sel_ie   = wr_en_i && (wr_addr_i == ADDR_W'(REG_IE));
    assign sel_we   = wr_en_i && (wr_addr_i == ADDR_W'(REG_WE));
    assign sel_clr  = wr_en_i && (wr_addr_i == ADDR_W'(REG_CLR));
    assign sel_swt  = wr_en_i && (wr_addr_i == ADDR_W'(REG_SWT));
    assign sel_fen  = wr_en_i && (wr_addr_i == ADDR_W'(REG_FEN));
    assign sel_flen = wr_en_i && (wr_addr_i == ADDR_W'(REG_FLEN));

    assign clr_m = sel_clr ? wr_data_i : '0;
    assign swt_m = sel_swt ? wr_data_i : '0;

    evl_sync #(.W(NUM_LINES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_i),
        .q_o   (sync_q)
    );

    // shared configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie_q   <= '0;
            we_q   <= '0;
            fen_q  <= '0;
            flen_q <= '0;
        end else begin
            if (sel_ie)   ie_q   <= wr_data_i;
            if (sel_we)   we_q   <= wr_data_i;
            if (sel_fen)  fen_q  <= wr_data_i;
            if (sel_flen) flen_q <= wr_data_i[FLT_W-1:0];
        end
    end

    // per-line path: filter, bypass select, trigger type, detector
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        logic [2:0] mode_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mode_q <= TRG_RISE;
            else if (wr_en_i && (wr_addr_i == ADDR_W'(NUM_LINES + i)))
                mode_q <= wr_data_i[2:0];
        end

        evl_filter #(.CNT_W(FLT_W)) u_flt (
            .clk     (clk),
            .rst_n   (rst_n),
            .raw_i   (sync_q[i]),
            .limit_i (flen_q),
            .level_o (flt_lvl[i])
        );

        assign line_lvl[i] = fen_q[i] ? flt_lvl[i] : sync_q[i];

        evl_detect u_det (
            .clk     (clk),
            .rst_n   (rst_n),
            .level_i (line_lvl[i]),
            .mode_i  (mode_q),
            .hit_o   (hit[i])
        );
    end

    // sticky pending bits: a set wins over a clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_m) | hit | swt_m;
    end

    assign pending_o = pend_q;
    assign irq_o     = |(pend_q & ie_q);
    assign wake_o    = |(pend_q & we_q);

endmodule

// File: rtl/evl_ctrl_chk.sv
module evl_ctrl_chk
    import evl_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int ADDR_W    = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en_i,
    input logic [ADDR_W-1:0]    wr_addr_i,
    input logic [NUM_LINES-1:0] wr_data_i,
    input logic [NUM_LINES-1:0] pending_o,
    input logic                 irq_o,
    input logic                 wake_o
);

    logic [NUM_LINES-1:0] clr_req;
    logic                 swt_req;

    assign clr_req = (wr_en_i && (wr_addr_i == ADDR_W'(REG_CLR))) ? wr_data_i : '0;
    assign swt_req = wr_en_i && (wr_addr_i == ADDR_W'(REG_SWT));

    // R6: set bits not being cleared remain set
    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pending_o & $past(pending_o & ~clr_req)) == $past(pending_o & ~clr_req)));

    // R8: a software trigger write sets the addressed bits
    assert_soft_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        swt_req |=> ((pending_o & $past(wr_data_i)) == $past(wr_data_i)));

    // R10: combined requests need a pending source
    assert_irq_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (pending_o != '0));

    assert_wake_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> (pending_o != '0));

endmodule

bind evl_ctrl evl_ctrl_chk #(
    .NUM_LINES (NUM_LINES),
    .ADDR_W    (ADDR_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .pending_o (pending_o),
    .irq_o     (irq_o),
    .wake_o    (wake_o)
);

// File: tb/evl_ctrl_tb.sv
module evl_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pin = '0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] pending;
    logic        irq, wake;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    evl_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_i     (pin),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .pending_o (pending),
        .irq_o     (irq),
        .wake_o    (wake)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        idle(1);
        chk("R1 reset pending", pending, 0);
        chk("R1 reset irq", irq, 0);
        chk("R1 reset wake", wake, 0);
    endtask

    task automatic t_rise;
        @(negedge clk) pin[0] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R2 not before third edge", pending, 16'h0000);
        @(negedge clk);
        chk("R2 R1 rise sets only line 0", pending, 16'h0001);
        chk("R11 irq off without enable", irq, 0);
        pin[0] = 1'b0;
        idle(4);
        chk("R6 sticky after pin low", pending, 16'h0001);
        wr(5'd2, 16'h0000);
        chk("R6 zero write keeps bit", pending, 16'h0001);
        wr(5'd2, 16'h0001);
        chk("R6 clear", pending, 16'h0000);
        // single-cycle pulse on an unfiltered line
        @(negedge clk) pin[1] = 1'b1;
        @(negedge clk) pin[1] = 1'b0;
        idle(4);
        chk("R9 unfiltered short pulse", pending, 16'h0002);
        wr(5'd2, 16'hFFFF);
    endtask

    task automatic t_fall_both;
        wr(5'd20, 16'd2);
        wr(5'd21, 16'd1);
        @(negedge clk) pin[5:4] = 2'b11;
        idle(4);
        chk("R3 rise: both sets, falling not", pending, 16'h0010);
        wr(5'd2, 16'hFFFF);
        @(negedge clk) pin[5:4] = 2'b00;
        idle(4);
        chk("R3 fall: both and falling set", pending, 16'h0030);
        wr(5'd2, 16'hFFFF);
    endtask

    task automatic t_level;
        wr(5'd19, 16'd3);
        @(negedge clk) pin[3] = 1'b1;
        idle(4);
        chk("R4 high level sets", pending, 16'h0008);
        wr(5'd2, 16'h0008);
        chk("R4 clear blocked while high", pending, 16'h0008);
        @(negedge clk) pin[3] = 1'b0;
        idle(4);
        chk("R4 stays after level gone", pending, 16'h0008);
        wr(5'd2, 16'h0008);
        chk("R4 clear after level gone", pending, 16'h0000);
        // low level on line 6
        wr(5'd22, 16'd5);
        @(negedge clk) pin[6] = 1'b1;
        idle(4);
        wr(5'd22, 16'd4);
        idle(3);
        chk("R4 low mode idle while high", pending, 16'h0000);
        @(negedge clk) pin[6] = 1'b0;
        idle(4);
        chk("R4 low level sets", pending, 16'h0040);
        wr(5'd2, 16'h0040);
        chk("R4 clear blocked while low", pending, 16'h0040);
        @(negedge clk) pin[6] = 1'b1;
        idle(4);
        wr(5'd2, 16'h0040);
        chk("R4 low cleared", pending, 16'h0000);
    endtask

    task automatic t_off;
        wr(5'd24, 16'd7);
        wr(5'd25, 16'd5);
        @(negedge clk) pin[9:8] = 2'b11;
        idle(3);
        @(negedge clk) pin[9:8] = 2'b00;
        idle(4);
        chk("R5 disabled codes never set", pending, 16'h0000);
    endtask

    task automatic t_collide;
        @(negedge clk) pin[10] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'd2; wr_data = 16'h0400;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R7 set wins over clear", pending, 16'h0400);
        wr(5'd2, 16'h0400);
        chk("R6 clear after collision", pending, 16'h0000);
        pin[10] = 1'b0;
        idle(3);
    endtask

    task automatic t_soft;
        wr(5'd27, 16'd5);
        wr(5'd3, 16'h0800);
        chk("R8 soft trigger on disabled line", pending, 16'h0800);
        wr(5'd3, 16'h3000);
        chk("R8 soft trigger two lines", pending, 16'h3800);
    endtask

    task automatic t_mask;
        chk("R11 pending without enables irq", irq, 0);
        chk("R11 pending without enables wake", wake, 0);
        wr(5'd0, 16'h1000);
        chk("R10 irq from enabled line", irq, 1);
        chk("R10 wake independent", wake, 0);
        wr(5'd0, 16'h0000);
        wr(5'd1, 16'h2000);
        chk("R10 wake from enabled line", wake, 1);
        chk("R10 irq masked", irq, 0);
        wr(5'd1, 16'h0000);
        wr(5'd0, 16'h4000);
        chk("R10 enable on idle line", irq, 0);
        wr(5'd0, 16'h0000);
        wr(5'd2, 16'hFFFF);
        chk("R6 clear all", pending, 16'h0000);
    endtask

    task automatic t_filter;
        wr(5'd4, 16'h0004);
        wr(5'd5, 16'd3);
        @(negedge clk) pin[2] = 1'b1;
        idle(4);
        pin[2] = 1'b0;
        idle(10);
        chk("R9 L+1 cycle pulse blocked", pending, 16'h0000);
        @(negedge clk) pin[2] = 1'b1;
        idle(5);
        pin[2] = 1'b0;
        idle(10);
        chk("R9 L+2 cycle pulse accepted", pending, 16'h0004);
        wr(5'd2, 16'hFFFF);
        wr(5'd4, 16'h0000);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        t_reset();
        t_rise();
        t_fall_both();
        t_level();
        t_off();
        t_collide();
        t_soft();
        t_mask();
        t_filter();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule